// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked host and an 8192 x 8 asynchronous static RAM that has no clock of its own. The host offers one word at a time on a valid/ready request port with an address, a write byte and a read/write flag. The controller turns each request into a sequence of chip-enable, write-enable and output-enable levels whose every interval is a whole number of clock cycles. A read returns its byte on a one-cycle response pulse.

All RAM timing minimums are given in nanoseconds and turned into cycle counts at elaboration. Each count is the time divided by the clock period, rounded up, and never less than one. A parameter chooses which signal ends a write. In one mode write enable forms the strobe while the chip stays selected. In the other, write enable is held low for the whole write and the chip-enable pair forms the strobe. A power guard keeps the active-high enable low while the supply is not reported good or retention is requested. After both conditions clear, it waits one full cycle time before it lets any access start.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the RAM is deselected (ram_ce1_no=1, ram_ce2_o=0), ram_we_no=1, ram_oe_no=1, ram_dq_oe_o=0, req_ready_o=0 and rsp_valid_o=0.
- R2: While pwr_ok_i is low, req_ready_o stays low. Once pwr_ok_i is high with retain_i low, req_ready_o rises exactly N_CYC = ceil(150 ns / clock period) cycles after the first clock edge that samples it high.
- R3: From the cycle after retain_i is sampled high, ram_ce2_o is low and req_ready_o is low. Requests offered meanwhile are not accepted and produce no strobe. After retain_i falls, req_ready_o returns N_CYC cycles later, and bytes stored before retention read back unchanged.
- R4: An accepted read keeps the RAM selected with ram_oe_no low and the address unchanged for N_RD = max(ceil(150 ns), ceil(70 ns)) cycles. It samples the bus at the N_RD-th edge after acceptance. rsp_valid_o is high with that byte in the following cycle only.
- R5: The write strobe (both enables active and ram_we_no low) lasts at least ceil(90 ns) cycles. The controller drives the write byte for at least ceil(60 ns) cycles before the strobe ends and still drives it, at the same address, in the cycle after.
- R6: The controller never drives ram_dq_o while ram_oe_no is low. It does not drive the bus during the first ceil(50 ns) cycles of a write strobe.
- R7: Two accepts are at least N_CYC cycles apart. A write takes ceil(50) + max(ceil(60), ceil(90)-ceil(50)) + ceil(10) cycles of strobe phases. With requests waiting, the next access after a write is accepted exactly max(N_CYC, that length + 1) cycles after it (8 at 20 ns).
- R8: With WR_CE_CTRL=1, ram_we_no is low for the whole write, including a hold cycle in which the RAM is deselected. With WR_CE_CTRL=0, ram_we_no is never low while the RAM is deselected.
- R9: In both write modes, a byte written to any address is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Supply has reached its minimum operating level |
| retain_i | input | 1 | Data-retention standby request |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write byte |
| rsp_valid_o | output | 1 | One-cycle read-data pulse |
| rsp_rdata_o | output | DATA_W | Captured read byte |
| ram_addr_o | output | ADDR_W | RAM address lines |
| ram_ce1_no | output | 1 | RAM chip enable, active low |
| ram_ce2_o | output | 1 | RAM chip enable, active high |
| ram_we_no | output | 1 | RAM write enable, active low |
| ram_oe_no | output | 1 | RAM output enable, active low |
| ram_dq_o | output | DATA_W | Data bus, controller to RAM |
| ram_dq_oe_o | output | 1 | Controller drives the data bus |
| ram_dq_i | input | DATA_W | Data bus, RAM to controller |

## Verification
A phase counter that is off by one shows up within one access. A read then returns the byte the RAM model presents before its access time has passed, and a write shows a strobe or data window one cycle short at the strobe end. A sequencer stuck outside idle holds ready low, so the next request is never accepted. A wrong guard count moves the first ready edge after power-up or retention by whole cycles. A lost or corrupted store is seen only when the read sweep reaches that address.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WHZ,
    ST_WDAT,
    ST_WHLD
  } seq_st_e;

  function automatic int unsigned ns2cyc(int unsigned t_ns, int unsigned clk_ps);
    int unsigned c;
    c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= RST_VAL;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_pwr_guard.sv
module sram_pwr_guard #(
  parameter int W = 4,
  parameter logic [W-1:0] WIN = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic retain_i,
  output logic avail_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic blk;
  assign blk = retain_i | ~pwr_ok_i;

  // window restarts on every blocked cycle
  sram_wait_cnt #(.W(W), .RST_VAL(WIN)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (blk),
    .val_i  (WIN),
    .zero_o (avail_o)
  );

  a_r2_blocked_unavail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk |=> !avail_o);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int W = 4,
  parameter bit WR_CE_CTRL = 1'b0,
  parameter logic [W-1:0] L_CYC = '0,
  parameter logic [W-1:0] L_RD  = '0,
  parameter logic [W-1:0] L_HZ  = '0,
  parameter logic [W-1:0] L_WD  = '0,
  parameter logic [W-1:0] L_WH  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              avail_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              sel_o,
  output logic              we_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  timeunit 1ns;
  timeprecision 1ps;

  seq_st_e state_q, state_d;
  logic ph_load, ph_zero, cyc_zero, acc, cap;
  logic [W-1:0] ph_val;

  assign req_ready_o = (state_q == ST_IDLE) && cyc_zero && avail_i;
  assign acc         = req_valid_i && req_ready_o;
  assign cap         = (state_q == ST_RD) && ph_zero;

  sram_wait_cnt #(.W(W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ph_load), .val_i(ph_val), .zero_o(ph_zero)
  );

  // cycle-time padding: address-to-address spacing
  sram_wait_cnt #(.W(W)) u_cycle (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(acc), .val_i(L_CYC), .zero_o(cyc_zero)
  );

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = '0;
    case (state_q)
      ST_IDLE: if (acc) begin
        ph_load = 1'b1;
        if (req_we_i) begin state_d = ST_WHZ; ph_val = L_HZ; end
        else          begin state_d = ST_RD;  ph_val = L_RD; end
      end
      ST_RD:   if (ph_zero) state_d = ST_IDLE;
      ST_WHZ:  if (ph_zero) begin state_d = ST_WDAT; ph_load = 1'b1; ph_val = L_WD; end
      ST_WDAT: if (ph_zero) begin state_d = ST_WHLD; ph_load = 1'b1; ph_val = L_WH; end
      ST_WHLD: if (ph_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  logic rd_d, strb_d, hld_d, sel_d, we_d, drv_d;
  assign rd_d   = (state_d == ST_RD);
  assign strb_d = (state_d == ST_WHZ) || (state_d == ST_WDAT);
  assign hld_d  = (state_d == ST_WHLD);
  assign drv_d  = (state_d == ST_WDAT) || hld_d;

  generate
    if (WR_CE_CTRL) begin : g_ce_strobe
      assign sel_d = rd_d | strb_d;
      assign we_d  = strb_d | hld_d;
    end else begin : g_we_strobe
      assign sel_d = rd_d | strb_d | hld_d;
      assign we_d  = strb_d;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sel_o       <= 1'b0;
      we_o        <= 1'b0;
      oe_o        <= 1'b0;
      dq_oe_o     <= 1'b0;
      ram_addr_o  <= '0;
      dq_o        <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      state_q     <= state_d;
      sel_o       <= sel_d;
      we_o        <= we_d;
      oe_o        <= rd_d;
      dq_oe_o     <= drv_d;
      rsp_valid_o <= cap;
      if (acc) begin
        ram_addr_o <= req_addr_i;
        dq_o       <= req_wdata_i;
      end
      if (cap) rsp_rdata_o <= dq_i;
    end
  end

  a_r6_no_drive_under_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !oe_o);
  a_r6_we_oe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> !oe_o);
  a_r4_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && $past(sel_o)) |-> $stable(ram_addr_o));
  a_r4_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r7_ready_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!sel_o && !we_o && !dq_oe_o));
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int CLK_PS     = 20000,
  parameter int T_CYC_NS   = 150,
  parameter int T_AA_NS    = 150,
  parameter int T_OE_NS    = 70,
  parameter int T_WP_NS    = 90,
  parameter int T_DS_NS    = 60,
  parameter int T_AH_NS    = 10,
  parameter int T_DH_NS    = 10,
  parameter int T_HZ_NS    = 50,
  parameter bit WR_CE_CTRL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              retain_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_ce1_no,
  output logic              ram_ce2_o,
  output logic              ram_we_no,
  output logic              ram_oe_no,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe_o,
  input  logic [DATA_W-1:0] ram_dq_i
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N_CYC = ns2cyc(T_CYC_NS, CLK_PS);
  localparam int N_RD  = umax(ns2cyc(T_AA_NS, CLK_PS), ns2cyc(T_OE_NS, CLK_PS));
  localparam int N_HZ  = ns2cyc(T_HZ_NS, CLK_PS);
  localparam int N_WP  = ns2cyc(T_WP_NS, CLK_PS);
  localparam int N_DS  = ns2cyc(T_DS_NS, CLK_PS);
  localparam int N_WD  = umax(N_DS, (N_WP > N_HZ) ? N_WP - N_HZ : 1);
  localparam int N_WH  = umax(ns2cyc(T_AH_NS, CLK_PS), ns2cyc(T_DH_NS, CLK_PS));
  localparam int N_MAX = umax(umax(N_CYC, N_RD), umax(umax(N_HZ, N_WD), N_WH));
  localparam int CW    = $clog2(N_MAX + 1);

  localparam logic [CW-1:0] L_CYC = CW'(N_CYC - 1);
  localparam logic [CW-1:0] L_RD  = CW'(N_RD - 1);
  localparam logic [CW-1:0] L_HZ  = CW'(N_HZ - 1);
  localparam logic [CW-1:0] L_WD  = CW'(N_WD - 1);
  localparam logic [CW-1:0] L_WH  = CW'(N_WH - 1);
  localparam logic [CW-1:0] L_WIN = CW'(N_CYC);

  logic avail, sel, we, oe;

  sram_pwr_guard #(.W(CW), .WIN(L_WIN)) u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_ok_i (pwr_ok_i),
    .retain_i (retain_i),
    .avail_o  (avail)
  );

  sram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .W(CW), .WR_CE_CTRL(WR_CE_CTRL),
    .L_CYC(L_CYC), .L_RD(L_RD), .L_HZ(L_HZ), .L_WD(L_WD), .L_WH(L_WH)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .avail_i     (avail),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .ram_addr_o  (ram_addr_o),
    .sel_o       (sel),
    .we_o        (we),
    .oe_o        (oe),
    .dq_o        (ram_dq_o),
    .dq_oe_o     (ram_dq_oe_o),
    .dq_i        (ram_dq_i)
  );

  assign ram_ce1_no = ~sel;
  assign ram_ce2_o  = sel & avail;  // held low through retention and power-up
  assign ram_we_no  = ~we;
  assign ram_oe_no  = ~oe;

  a_r3_ce2_low_retain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retain_i |=> !ram_ce2_o);
  a_r2_ce2_low_no_pwr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> !ram_ce2_o);
endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test_ram #(
  parameter int AW   = 10,
  parameter int N_RD = 8,
  parameter int N_HZ = 3,
  parameter int N_WP = 5,
  parameter int N_DS = 3
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ce1_ni,
  input  logic          ce2_i,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [7:0]    dq_i,
  input  logic          dq_oe_i,
  output logic [7:0]    dq_o,
  output int            viol_wr_o,
  output int            viol_bus_o,
  output int            we_desel_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [7:0] mem [1<<AW];
  int age, slen, dlen;
  logic strb_q;
  logic [AW-1:0] saddr, raddr;
  wire sel  = !ce1_ni && ce2_i;
  wire strb = sel && !we_ni;
  wire rd   = sel && !oe_ni && we_ni;

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = 8'h00;
    age = 0; slen = 0; dlen = 0; strb_q = 1'b0; saddr = '0; raddr = '0;
    viol_wr_o = 0; viol_bus_o = 0; we_desel_o = 0;
  end

  // output is wrong until the access time has elapsed
  assign dq_o = rd ? ((age >= N_RD) ? mem[addr_i] : ~mem[addr_i]) : 8'h00;

  always @(negedge clk_i) begin
    if (rd) begin
      if (age == 0 || addr_i == raddr) age = age + 1;
      else age = 1;
      raddr = addr_i;
    end else age = 0;
    if (dq_oe_i && !oe_ni) viol_bus_o = viol_bus_o + 1;
    if (!we_ni && !sel) we_desel_o = we_desel_o + 1;
    if (strb) begin
      if (!strb_q) begin slen = 1; dlen = 0; saddr = addr_i; end
      else slen = slen + 1;
      if (addr_i != saddr) viol_wr_o = viol_wr_o + 1;
      if (dq_oe_i) begin
        if (slen <= N_HZ) viol_bus_o = viol_bus_o + 1;
        dlen = dlen + 1;
      end else if (dlen > 0) viol_wr_o = viol_wr_o + 1;
    end else if (strb_q) begin
      if (slen < N_WP || dlen < N_DS || !dq_oe_i || addr_i != saddr)
        viol_wr_o = viol_wr_o + 1;
      mem[saddr] = dq_i;
    end
    strb_q = strb;
  end
endmodule

module sram_ctrl_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PS = 20000;
  localparam int AW = 10;

  function automatic int tcyc(int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_CYC  = tcyc(150);
  localparam int E_RD   = mx(tcyc(150), tcyc(70));
  localparam int E_HZ   = tcyc(50);
  localparam int E_WP   = tcyc(90);
  localparam int E_DS   = tcyc(60);
  localparam int E_WLEN = E_HZ + mx(E_DS, mx(E_WP - E_HZ, 1)) + mx(tcyc(10), tcyc(10));
  localparam int E_WGAP = mx(E_CYC, E_WLEN + 1);

  logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b0, retain = 1'b0;
  logic valid = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;

  logic rdy0, rdy1, rv0, rv1, ce1n0, ce1n1, ce20, ce21, wen0, wen1, oen0, oen1, doe0, doe1;
  logic [7:0] rd0, rd1, dqo0, dqo1, dqi0, dqi1;
  logic [AW-1:0] ra0, ra1;
  int vw0, vw1, vb0, vb1, wd0, wd1;

  int checks = 0, errs = 0, cyc_n = 0, last_acc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 20 ns period
  always @(posedge clk) cyc_n++;

  sram_ctrl #(.ADDR_W(AW), .CLK_PS(CLK_PS), .WR_CE_CTRL(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .retain_i(retain),
    .req_valid_i(valid), .req_ready_o(rdy0), .req_we_i(we), .req_addr_i(addr),
    .req_wdata_i(wdata), .rsp_valid_o(rv0), .rsp_rdata_o(rd0), .ram_addr_o(ra0),
    .ram_ce1_no(ce1n0), .ram_ce2_o(ce20), .ram_we_no(wen0), .ram_oe_no(oen0),
    .ram_dq_o(dqo0), .ram_dq_oe_o(doe0), .ram_dq_i(dqi0));

  sram_ctrl #(.ADDR_W(AW), .CLK_PS(CLK_PS), .WR_CE_CTRL(1'b1)) uut_ce (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .retain_i(retain),
    .req_valid_i(valid), .req_ready_o(rdy1), .req_we_i(we), .req_addr_i(addr),
    .req_wdata_i(wdata), .rsp_valid_o(rv1), .rsp_rdata_o(rd1), .ram_addr_o(ra1),
    .ram_ce1_no(ce1n1), .ram_ce2_o(ce21), .ram_we_no(wen1), .ram_oe_no(oen1),
    .ram_dq_o(dqo1), .ram_dq_oe_o(doe1), .ram_dq_i(dqi1));

  sram_ctrl_test_ram #(.AW(AW), .N_RD(E_RD), .N_HZ(E_HZ), .N_WP(E_WP), .N_DS(E_DS)) m0 (
    .clk_i(clk), .addr_i(ra0), .ce1_ni(ce1n0), .ce2_i(ce20), .we_ni(wen0), .oe_ni(oen0),
    .dq_i(dqo0), .dq_oe_i(doe0), .dq_o(dqi0), .viol_wr_o(vw0), .viol_bus_o(vb0),
    .we_desel_o(wd0));

  sram_ctrl_test_ram #(.AW(AW), .N_RD(E_RD), .N_HZ(E_HZ), .N_WP(E_WP), .N_DS(E_DS)) m1 (
    .clk_i(clk), .addr_i(ra1), .ce1_ni(ce1n1), .ce2_i(ce21), .we_ni(wen1), .oe_ni(oen1),
    .dq_i(dqo1), .dq_oe_i(doe1), .dq_o(dqi1), .viol_wr_o(vw1), .viol_bus_o(vb1),
    .we_desel_o(wd1));

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + (a >> 5)) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(bit w, int a, int d, output int gap);
    @(negedge clk);
    valid = 1'b1; we = w; addr = AW'(a); wdata = 8'(d);
    while (!rdy0) @(negedge clk);
    gap = cyc_n + 1 - last_acc;
    last_acc = cyc_n + 1;
    chk(rdy1 == rdy0, "R7 ready agreement", rdy1, rdy0);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic do_read(int a, logic [7:0] exp);
    int g;
    bit early;
    issue(1'b0, a, 0, g);
    chk(g >= E_CYC, "R7 read spacing", g, E_CYC);
    early = 1'b0;
    for (int k = 1; k <= E_RD; k++) begin
      @(negedge clk);
      if (k < E_RD && (rv0 || rv1)) early = 1'b1;
    end
    chk(!early && rv0 && rv1, "R4 read latency", {rv1, rv0}, 3);
    chk(rd0 == exp, "R9 read data we-mode", rd0, exp);
    chk(rd1 == exp, "R9 read data ce-mode", rd1, exp);
    @(negedge clk);
    chk(!rv0 && !rv1, "R4 response pulse width", {rv1, rv0}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_n, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    chk({ce1n0, ce20, wen0, oen0, doe0, rdy0, rv0} == 7'b1011000, "R1 reset we-mode",
        {ce1n0, ce20, wen0, oen0, doe0, rdy0, rv0}, 7'b1011000);
    chk({ce1n1, ce21, wen1, oen1, doe1, rdy1, rv1} == 7'b1011000, "R1 reset ce-mode",
        {ce1n1, ce21, wen1, oen1, doe1, rdy1, rv1}, 7'b1011000);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ce1n0, ce20, wen0, oen0, doe0} == 5'b10110, "R1 after release",
        {ce1n0, ce20, wen0, oen0, doe0}, 5'b10110);
    repeat (5) @(negedge clk);
    chk(!rdy0 && !rdy1, "R2 no ready without power", {rdy1, rdy0}, 0);

    pwr_ok = 1'b1;
    for (int k = 1; k <= E_CYC; k++) begin
      @(negedge clk);
      if (k == E_CYC - 1) chk(!rdy0 && !rdy1, "R2 window not yet over", {rdy1, rdy0}, 0);
      if (k == E_CYC) chk(rdy0 && rdy1, "R2 ready after window", {rdy1, rdy0}, 3);
    end

    for (int a = 0; a < (1 << AW); a++) begin
      issue(1'b1, a, pat(a), g);
      if (a > 0) chk(g == E_WGAP, "R7 write spacing", g, E_WGAP);
    end
    repeat (E_CYC) @(negedge clk);
    chk(vw0 == 0, "R5 write strobe we-mode", vw0, 0);
    chk(vw1 == 0, "R5 write strobe ce-mode", vw1, 0);
    chk(vb0 == 0 && vb1 == 0, "R6 bus turnaround", vb0 + vb1, 0);
    chk(wd0 == 0, "R8 we-mode keeps we inside select", wd0, 0);
    chk(wd1 == (1 << AW), "R8 ce-mode we low past select", wd1, 1 << AW);

    @(negedge clk);
    retain = 1'b1;
    @(negedge clk);
    chk(!ce20 && !ce21 && !rdy0 && !rdy1, "R3 retention entry", {ce21, ce20, rdy1, rdy0}, 0);
    valid = 1'b1; we = 1'b1; addr = AW'(5); wdata = ~pat(5);
    begin
      bit bad;
      bad = 1'b0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (rdy0 || rdy1 || !ce1n0 || !ce1n1 || !wen0 || !wen1 || ce20 || ce21) bad = 1'b1;
      end
      chk(!bad, "R3 request ignored in retention", bad, 0);
    end
    valid = 1'b0;
    retain = 1'b0;
    for (int k = 1; k <= E_CYC; k++) begin
      @(negedge clk);
      if (k == E_CYC - 1) chk(!rdy0, "R3 exit window", rdy0, 0);
      if (k == E_CYC) chk(rdy0 && rdy1, "R3 ready after exit", {rdy1, rdy0}, 3);
    end
    last_acc = 0;

    do_read(5, pat(5));  // R3 content kept through retention
    for (int a = 0; a < (1 << AW); a++) do_read(a, pat(a));
    chk(vb0 == 0 && vb1 == 0, "R6 no drive during reads", vb0 + vb1, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule